// File: doc/BRIEF.md
# Shift-Register Display Timing Generator

This block produces the raster timing for a 576 by 455 monochrome bitmap shown at VGA-compatible scan rates. The design clock is the system clock, and each clock carries two pixels. A horizontal position advances once per clock. A vertical position advances once per line. Flag registers decode these two positions into a horizontal video enable, a vertical video enable, active-low horizontal and vertical sync, and a combined video-on signal. A one-clock frame-start pulse tells the pixel fetch logic to rewind its memory address.

Neither position is a binary count. Each one is a maximal-length feedback shift register that is cut short to the line or frame period. On the terminal state, the feedback bit is inverted, and this closes a loop of exactly the required length. The start state, the terminal state and the eight decode patterns are all computed at elaboration from the period parameters. Each flag is a set/clear register that responds to two of these patterns.

Top module: `lfsr_vsync`

## Requirements
- R1: While reset is held and in the first clock after it is released: `h_en`=0, `v_en`=1, `hsync_n`=1, `vsync_n`=1, `frame_start`=0 and `video_on`=0. The first clock after release is horizontal position 0 of line 0.
- R2: The horizontal position h starts at 0 after reset. It rises by one each clock and wraps from H_TOTAL-1 (380) to 0, so a line lasts H_TOTAL clocks.
- R3: `h_en` is 1 exactly when h is from 1 to H_VIS (288). The enable is one clock late relative to h.
- R4: `hsync_n` is 0 exactly when h is from H_SYNC_ON+1 (309) to H_SYNC_OFF (353), so the pulse is 45 clocks wide.
- R5: The line number v starts at 0 after reset. It rises by one when h wraps to 0 and wraps from V_TOTAL-1 (527) to 0.
- R6: `v_en` is 1 exactly on lines 0 to V_VIS-1 (454). It changes only at h=0.
- R7: `vsync_n` is 0 exactly on lines V_SYNC_ON (486) to V_SYNC_OFF-1 (487).
- R8: `frame_start` is 1 for exactly one clock, at h=0 of line 0, each time v wraps. It is never 1 after a reset.
- R9: `video_on` is 1 exactly when `h_en` and `v_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two pixels per clock |
| rst | input | 1 | Synchronous reset, active high |
| h_en | output | 1 | Horizontal video enable (one clock late) |
| v_en | output | 1 | Vertical video enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| frame_start | output | 1 | One-clock pulse at the start of each frame after the first |
| video_on | output | 1 | Both enables true |

## Verification
The block has only a reset input, so the assertions assume only one thing: the parameters keep the blanking, sync-on, sync-off and total points in strictly increasing order. Under that ordering, sync can only occur inside blanking, and the vertical flags can only move while the horizontal enable is low. The bench keeps the real horizontal timing but shortens the frame to 60 lines, with the same ordering. It then follows two full frames clock by clock against a binary reference position.

// File: rtl/lfsr_vsync.sv
module lfsr_vsync #(
  parameter int H_BITS     = 9,
  parameter int H_TAP      = 5,
  parameter int H_VIS      = 288,
  parameter int H_SYNC_ON  = 308,
  parameter int H_SYNC_OFF = 353,
  parameter int H_TOTAL    = 381,
  parameter int V_BITS     = 10,
  parameter int V_TAP      = 7,
  parameter int V_VIS      = 455,
  parameter int V_SYNC_ON  = 486,
  parameter int V_SYNC_OFF = 488,
  parameter int V_TOTAL    = 528
) (
  input  logic clk,
  input  logic rst,
  output logic h_en,
  output logic v_en,
  output logic hsync_n,
  output logic vsync_n,
  output logic frame_start,
  output logic video_on
);

  function automatic logic [31:0] lf_next(input logic [31:0] s, input int w, input int tap);
    logic [31:0] msk;
    logic        fb;
    msk = (32'h1 << w) - 32'h1;
    fb  = s[w-1] ^ s[tap-1];
    return ((s << 1) | {31'h0, fb}) & msk;
  endfunction

  function automatic logic [31:0] lf_adv(input logic [31:0] s, input int n, input int w, input int tap);
    logic [31:0] x;
    x = s;
    for (int i = 0; i < n; i++) x = lf_next(x, w, tap);
    return x;
  endfunction

  // start state whose (m-1)th successor, with inverted feedback, returns to it
  function automatic logic [31:0] lf_seed(input int w, input int tap, input int m);
    logic [31:0] a, b;
    a = 32'h1;
    b = lf_adv(32'h1, m - 1, w, tap);
    for (int j = 0; j < (1 << w); j++) begin
      if ((lf_next(b, w, tap) ^ 32'h1) == a) return a;
      a = lf_next(a, w, tap);
      b = lf_next(b, w, tap);
    end
    return 32'h1;
  endfunction

  localparam logic [31:0] HS32 = lf_seed(H_BITS, H_TAP, H_TOTAL);
  localparam logic [31:0] VS32 = lf_seed(V_BITS, V_TAP, V_TOTAL);

  localparam logic [H_BITS-1:0] H_SEED   = HS32[H_BITS-1:0];
  localparam logic [31:0]       HT32     = lf_adv(HS32, H_TOTAL - 1, H_BITS, H_TAP);
  localparam logic [31:0]       HC32     = lf_adv(HS32, H_VIS, H_BITS, H_TAP);
  localparam logic [31:0]       HL32     = lf_adv(HS32, H_SYNC_ON, H_BITS, H_TAP);
  localparam logic [31:0]       HH32     = lf_adv(HS32, H_SYNC_OFF, H_BITS, H_TAP);
  localparam logic [H_BITS-1:0] H_TERM   = HT32[H_BITS-1:0];
  localparam logic [H_BITS-1:0] H_EN_OFF = HC32[H_BITS-1:0];
  localparam logic [H_BITS-1:0] H_SY_LO  = HL32[H_BITS-1:0];
  localparam logic [H_BITS-1:0] H_SY_HI  = HH32[H_BITS-1:0];

  localparam logic [V_BITS-1:0] V_SEED   = VS32[V_BITS-1:0];
  localparam logic [31:0]       VT32     = lf_adv(VS32, V_TOTAL - 1, V_BITS, V_TAP);
  localparam logic [31:0]       VC32     = lf_adv(VS32, V_VIS - 1, V_BITS, V_TAP);
  localparam logic [31:0]       VL32     = lf_adv(VS32, V_SYNC_ON - 1, V_BITS, V_TAP);
  localparam logic [31:0]       VH32     = lf_adv(VS32, V_SYNC_OFF - 1, V_BITS, V_TAP);
  localparam logic [V_BITS-1:0] V_TERM   = VT32[V_BITS-1:0];
  localparam logic [V_BITS-1:0] V_EN_OFF = VC32[V_BITS-1:0];
  localparam logic [V_BITS-1:0] V_SY_LO  = VL32[V_BITS-1:0];
  localparam logic [V_BITS-1:0] V_SY_HI  = VH32[V_BITS-1:0];

  logic [H_BITS-1:0] hq;
  logic [V_BITS-1:0] vq;
  logic line_end, frame_end, h_fb, v_fb;

  assign line_end  = (hq == H_TERM);
  assign frame_end = (vq == V_TERM);
  assign h_fb      = hq[H_BITS-1] ^ hq[H_TAP-1] ^ line_end;
  assign v_fb      = vq[V_BITS-1] ^ vq[V_TAP-1] ^ frame_end;
  assign video_on  = h_en & v_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      hq <= H_SEED;
      vq <= V_SEED;
    end else begin
      hq <= {hq[H_BITS-2:0], h_fb};
      if (line_end) vq <= {vq[V_BITS-2:0], v_fb};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_en    <= 1'b0;
      hsync_n <= 1'b1;
    end else begin
      if (hq == H_SEED)        h_en <= 1'b1;
      else if (hq == H_EN_OFF) h_en <= 1'b0;
      if (hq == H_SY_LO)       hsync_n <= 1'b0;
      else if (hq == H_SY_HI)  hsync_n <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_en        <= 1'b1;
      vsync_n     <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      frame_start <= line_end & frame_end;
      if (line_end) begin
        if (frame_end)           v_en <= 1'b1;
        else if (vq == V_EN_OFF) v_en <= 1'b0;
        if (vq == V_SY_LO)       vsync_n <= 1'b0;
        else if (vq == V_SY_HI)  vsync_n <= 1'b1;
      end
    end
  end

endmodule

module lfsr_vsync_chk (
  input logic clk,
  input logic rst,
  input logic h_en,
  input logic v_en,
  input logic hsync_n,
  input logic vsync_n,
  input logic frame_start,
  input logic video_on
);
  // R8
  fs_single_chk: assert property (@(posedge clk) disable iff (rst) frame_start |=> !frame_start);
  // R8
  fs_phase_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (v_en && !h_en && vsync_n && hsync_n));
  // R4
  hsync_blank_chk: assert property (@(posedge clk) disable iff (rst) !hsync_n |-> !h_en);
  // R4
  hsync_width_chk: assert property (@(posedge clk) disable iff (rst) $fell(hsync_n) |=> !hsync_n);
  // R7
  vsync_blank_chk: assert property (@(posedge clk) disable iff (rst) !vsync_n |-> !v_en);
  // R6
  vedge_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(v_en) || !$stable(vsync_n)) |-> !h_en);
  // R9
  video_gate_chk: assert property (@(posedge clk) disable iff (rst) video_on |-> (h_en && v_en));
endmodule

bind lfsr_vsync lfsr_vsync_chk chk_i (.*);

// File: tb/lfsr_vsync_tb_top.sv
module lfsr_vsync_tb_top;
  localparam int HT = 381, HV = 288, HSON = 308, HSOFF = 353;
  localparam int VT = 60, VV = 45, VSON = 48, VSOFF = 50;
  localparam int NCYC = 2 * VT * HT + 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic h_en, v_en, hsync_n, vsync_n, frame_start, video_on;

  typedef struct packed {
    logic hen, ven, hs, vs, fs, vid;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   started = 1'b0;
  bit   finished = 1'b0;

  always #2 clk = ~clk;

  lfsr_vsync #(.V_VIS(VV), .V_SYNC_ON(VSON), .V_SYNC_OFF(VSOFF), .V_TOTAL(VT)) dut_i (
    .clk(clk), .rst(rst), .h_en(h_en), .v_en(v_en), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .frame_start(frame_start), .video_on(video_on));

  task automatic cmp(input string req, input logic act, input logic expv, input int k);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, k, act, expv);
    end
  endtask

  function automatic exp_t model(input int k);
    exp_t e;
    int h, v, f;
    h = k % HT;
    v = (k / HT) % VT;
    f = k / (HT * VT);
    e.hen = (h >= 1 && h <= HV);
    e.hs  = !(h >= HSON + 1 && h <= HSOFF);
    e.ven = (v < VV);
    e.vs  = !(v >= VSON && v < VSOFF);
    e.fs  = (h == 0 && v == 0 && f > 0);
    e.vid = e.hen && e.ven;
    return e;
  endfunction

  // driver: pushes one expected item per clock
  initial begin
    repeat (3) @(negedge clk);
    // R1 values while reset is held
    cmp("R1 h_en", h_en, 1'b0, -1);
    cmp("R1 v_en", v_en, 1'b1, -1);
    cmp("R1 hsync_n", hsync_n, 1'b1, -1);
    cmp("R1 vsync_n", vsync_n, 1'b1, -1);
    cmp("R1 frame_start", frame_start, 1'b0, -1);
    cmp("R1 video_on", video_on, 1'b0, -1);
    rst = 1'b0;
    q.push_back(model(0));
    started = 1'b1;
    for (int k = 1; k < NCYC; k++) begin
      @(posedge clk);
      #1;
      q.push_back(model(k));
    end
  end

  // monitor: pops and compares between edges
  initial begin
    wait (started);
    for (int k = 0; k < NCYC; k++) begin
      exp_t e;
      if (k > 0) @(negedge clk);
      e = q.pop_front();
      cmp("R3 h_en", h_en, e.hen, k);
      cmp("R4 hsync_n", hsync_n, e.hs, k);
      cmp("R6 v_en (R5 line count)", v_en, e.ven, k);
      cmp("R7 vsync_n", vsync_n, e.vs, k);
      cmp("R8 frame_start (R2 line period)", frame_start, e.fs, k);
      cmp("R9 video_on", video_on, e.vid, k);
    end
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule